// File: doc/BRIEF.md
# Power-Good Blanking and Phase Sequencer

This block decides how many phases a multiphase core regulator drives, whether the controller skips pulses or runs forced PWM, and when the power-good and clock-enable window comparators may report. It watches a deep-sleep request from the processor, a busy flag and an at-target flag from the slew-rate generator, a comparator bit that says the output is above the internal target, and a one-microsecond tick. Whenever the target moves, the comparator thresholds are blanked. They come back only after a settling window of `BLANK_US` ticks that starts once the target has arrived.

In deep sleep, phases 2 and 3 are turned off and the controller skips pulses. After the window in deep sleep only the lower threshold is enabled, because the output is allowed to drift down under load. The way out of deep sleep depends on the comparator. If the output still sits above the target, a fast exit asks the slew generator for its fast rate and keeps skipping until the output meets the target. Otherwise a standard exit restores all phases and forced PWM at once. The deep-sleep request is asynchronous and goes through a synchronizer first.

Top module: `pg_phase_seq`

## Requirements
- R1: Synchronous reset puts the block in the run mode (`ph2_en`=1, `ph3_en`=1, `ph3_hiz`=0, `skip_mode`=0, `slew_fast`=0) with all four threshold enables at 0. Ticks alone never enable them until a settling window completes.
- R2: `slew_busy` high at a clock edge forces all four threshold enables to 0 after that edge. In run mode it also starts a transition.
- R3: Once a transition has `at_target`=1 and `slew_busy`=0, both lower and upper enables rise on the edge that samples the `BLANK_US`-th tick of that settled interval, and not before. The block is then in run mode.
- R4: A new `slew_busy` during the settling window blanks again and restarts the window from a full count.
- R5: A high `sleep_req` is used after a `SYNC_STAGES`-flop synchronizer. On the next edge the block enters the sleep mode (`ph2_en`=0, `ph3_en`=0, `ph3_hiz`=1, `skip_mode`=1) with all enables at 0.
- R6: In deep sleep, `BLANK_US` ticks after the target settles, only the lower enables rise. The upper enables stay 0 for as long as `skip_mode` is 1.
- R7: If `sleep_req` falls while `out_above`=0, the block returns to run mode at once and stays blanked. Both enables rise `BLANK_US` ticks after the target settles.
- R8: If `sleep_req` falls while `out_above`=1, the block keeps the sleep mode, raises `slew_fast` and stays blanked until `out_above` falls. It then enters run mode with `slew_fast`=0 and enables both thresholds `BLANK_US` ticks later.
- R9: `ck_lo_en` and `ck_hi_en` always equal `pg_lo_en` and `pg_hi_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Asynchronous deep-sleep request |
| slew_busy | input | 1 | Slew generator is moving the target |
| at_target | input | 1 | Slew generator target equals the commanded code |
| out_above | input | 1 | Output voltage is above the internal target |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| ph2_en | output | 1 | Phase 2 drivers enabled (0 forces both drives low) |
| ph3_en | output | 1 | Phase 3 PWM enabled |
| ph3_hiz | output | 1 | Phase 3 PWM output three-stated |
| skip_mode | output | 1 | 1 = pulse skipping, 0 = forced PWM |
| slew_fast | output | 1 | Request for the fast slew rate during a fast exit |
| pg_lo_en | output | 1 | Power-good lower threshold enabled |
| pg_hi_en | output | 1 | Power-good upper threshold enabled |
| ck_lo_en | output | 1 | Clock-enable lower threshold enabled |
| ck_hi_en | output | 1 | Clock-enable upper threshold enabled |

## Verification
The bench builds the block with `BLANK_US` = 20 and `SYNC_STAGES` = 2, the values used in practice. The tick is a bench-driven input, so a full 20 µs window costs only 40 clocks. This puts the exact 19th and 20th ticks within reach, along with a restart after 10 ticks and a long stay in deep sleep, all in one short run. With the two-flop synchronizer, the bench can also observe the cycle just before deep-sleep entry and the cycle just before an exit.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    typedef enum logic [2:0] {
        IDLE_PWM   = 3'd0,
        TRANSITION = 3'd1,
        BLANK_WAIT = 3'd2,
        DEEP_SLEEP = 3'd3,
        FAST_EXIT  = 3'd4,
        STD_EXIT   = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic ph2_on;
        logic ph3_on;
        logic ph3_float;
        logic skip;
        logic fast_req;
    } drive_t;

    // States where the settling timer may count down
    function automatic logic is_settle_state(seq_state_e s);
        return (s == BLANK_WAIT) || (s == DEEP_SLEEP);
    endfunction

    // States where the controller runs reduced-phase, pulse-skipping
    function automatic logic is_light_state(seq_state_e s);
        return (s == DEEP_SLEEP) || (s == FAST_EXIT);
    endfunction

endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/pgs_blank_timer.sv
module pgs_blank_timer #(
    parameter int COUNT = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic reload,
    input  logic tick,
    output logic fire
);
    localparam int W = $clog2(COUNT + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || reload)               cnt <= W'(COUNT);
        else if (tick && cnt != '0)      cnt <= cnt - W'(1);
    end

    assign fire = tick && !reload && (cnt == W'(1));
endmodule

// File: rtl/pgs_drive_dec.sv
module pgs_drive_dec
    import pgs_pkg::*;
(
    input  seq_state_e state,
    output drive_t     drv
);
    always_comb begin
        drv = '0;
        if (is_light_state(state)) begin
            drv.ph2_on    = 1'b0;
            drv.ph3_on    = 1'b0;
            drv.ph3_float = 1'b1;
            drv.skip      = 1'b1;
        end else begin
            drv.ph2_on    = 1'b1;
            drv.ph3_on    = 1'b1;
            drv.ph3_float = 1'b0;
            drv.skip      = 1'b0;
        end
        drv.fast_req = (state == FAST_EXIT);
    end
endmodule

// File: rtl/pg_phase_seq.sv
module pg_phase_seq
    import pgs_pkg::*;
#(
    parameter int BLANK_US    = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    input  logic slew_busy,
    input  logic at_target,
    input  logic out_above,
    input  logic us_tick,
    output logic ph2_en,
    output logic ph3_en,
    output logic ph3_hiz,
    output logic skip_mode,
    output logic slew_fast,
    output logic pg_lo_en,
    output logic pg_hi_en,
    output logic ck_lo_en,
    output logic ck_hi_en
);
    seq_state_e state, state_nx;
    drive_t     drv;
    logic       sleep_s;
    logic       settled;
    logic       reload;
    logic       fire;
    logic       lo_q, hi_q;

    pgs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (sleep_req),
        .dout(sleep_s)
    );

    assign settled = at_target && !slew_busy;

    // Timer restarts whenever the block is not in a settling state,
    // the target is not settled, or the state is about to be left.
    assign reload = !is_settle_state(state) || !settled
                  || ((state == BLANK_WAIT) && sleep_s)
                  || ((state == DEEP_SLEEP) && !sleep_s);

    pgs_blank_timer #(.COUNT(BLANK_US)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .reload(reload),
        .tick  (us_tick),
        .fire  (fire)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            IDLE_PWM: begin
                if (sleep_s)        state_nx = DEEP_SLEEP;
                else if (slew_busy) state_nx = TRANSITION;
            end
            TRANSITION: begin
                if (sleep_s)        state_nx = DEEP_SLEEP;
                else if (settled)   state_nx = BLANK_WAIT;
            end
            BLANK_WAIT: begin
                if (sleep_s)        state_nx = DEEP_SLEEP;
                else if (slew_busy) state_nx = TRANSITION;
                else if (fire)      state_nx = IDLE_PWM;
            end
            DEEP_SLEEP: begin
                if (!sleep_s)       state_nx = out_above ? FAST_EXIT : STD_EXIT;
            end
            FAST_EXIT: begin
                if (sleep_s)        state_nx = DEEP_SLEEP;
                else if (!out_above) state_nx = BLANK_WAIT;
            end
            STD_EXIT: begin
                if (sleep_s)        state_nx = DEEP_SLEEP;
                else if (settled)   state_nx = BLANK_WAIT;
            end
            default:                state_nx = IDLE_PWM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= IDLE_PWM;
        else     state <= state_nx;
    end

    pgs_drive_dec u_dec (
        .state(state),
        .drv  (drv)
    );

    // Threshold enables: window expiry opens lower, and upper only
    // in forced-PWM; any restart of the window blanks both.
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= 1'b0;
            hi_q <= 1'b0;
        end else if (fire) begin
            lo_q <= 1'b1;
            hi_q <= !drv.skip;
        end else if (reload && (state_nx != IDLE_PWM)) begin
            lo_q <= 1'b0;
            hi_q <= 1'b0;
        end
    end

    assign ph2_en    = drv.ph2_on;
    assign ph3_en    = drv.ph3_on;
    assign ph3_hiz   = drv.ph3_float;
    assign skip_mode = drv.skip;
    assign slew_fast = drv.fast_req;
    assign pg_lo_en  = lo_q;
    assign pg_hi_en  = hi_q;
    assign ck_lo_en  = lo_q;
    assign ck_hi_en  = hi_q;
endmodule

// File: rtl/pgs_checker.sv
module pgs_checker (
    input logic clk,
    input logic rst,
    input logic slew_busy,
    input logic us_tick,
    input logic ph2_en,
    input logic skip_mode,
    input logic slew_fast,
    input logic pg_lo_en,
    input logic pg_hi_en
);
    // R2
    busy_blanks_chk: assert property (@(posedge clk) disable iff (rst)
        slew_busy |=> (!pg_lo_en && !pg_hi_en));

    // R3
    lo_open_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pg_lo_en) |-> $past(us_tick));

    // R5
    sleep_entry_blank_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(skip_mode) |-> (!pg_lo_en && !pg_hi_en));

    // R6
    no_upper_in_skip_chk: assert property (@(posedge clk) disable iff (rst)
        skip_mode |-> !pg_hi_en);

    // R8
    fast_exit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        slew_fast |-> (skip_mode && !ph2_en && !pg_lo_en));
endmodule

bind pg_phase_seq pgs_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .slew_busy(slew_busy),
    .us_tick  (us_tick),
    .ph2_en   (ph2_en),
    .skip_mode(skip_mode),
    .slew_fast(slew_fast),
    .pg_lo_en (pg_lo_en),
    .pg_hi_en (pg_hi_en)
);

// File: tb/tb_pg_phase_seq.sv
`timescale 1ns/1ps
module tb_pg_phase_seq;
    localparam int WIN = 20;

    logic clk = 1'b0;
    logic rst, sleep_req, slew_busy, at_target, out_above, us_tick;
    logic ph2_en, ph3_en, ph3_hiz, skip_mode, slew_fast;
    logic pg_lo_en, pg_hi_en, ck_lo_en, ck_hi_en;

    always #2.5 clk = ~clk;

    pg_phase_seq #(.BLANK_US(WIN), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .slew_busy(slew_busy),
        .at_target(at_target), .out_above(out_above), .us_tick(us_tick),
        .ph2_en(ph2_en), .ph3_en(ph3_en), .ph3_hiz(ph3_hiz),
        .skip_mode(skip_mode), .slew_fast(slew_fast),
        .pg_lo_en(pg_lo_en), .pg_hi_en(pg_hi_en),
        .ck_lo_en(ck_lo_en), .ck_hi_en(ck_hi_en)
    );

    typedef struct {
        string      req;
        logic [8:0] exp;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // {ph2, ph3, hiz, skip, fast, pg_lo, pg_hi, ck_lo, ck_hi}
    function automatic logic [8:0] mk(bit slp, bit fst, bit lo, bit hi);
        logic [3:0] m;
        m = slp ? 4'b0011 : 4'b1100;
        return {m, fst, lo, hi, lo, hi};
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_st(string req, bit slp, bit fst, bit lo, bit hi);
        item_t it;
        it.req = req;
        it.exp = mk(slp, fst, lo, hi);
        q.push_back(it);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            us_tick = 1'b1; step(1);
            us_tick = 1'b0; step(1);
        end
    endtask

    // Monitor: compares outputs in the middle of the low phase
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() != 0) begin
                item_t it;
                logic [8:0] act;
                it  = q.pop_front();
                act = {ph2_en, ph3_en, ph3_hiz, skip_mode, slew_fast,
                       pg_lo_en, pg_hi_en, ck_lo_en, ck_hi_en};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%b expected=%b", it.req, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; sleep_req = 0; slew_busy = 0; at_target = 1;
        out_above = 0; us_tick = 0;
        step(3);
        rst = 0;
        expect_st("R1/R9 reset state", 0, 0, 0, 0);
        ticks(25);
        expect_st("R1 ticks alone keep blanked", 0, 0, 0, 0);

        // Plain transition
        slew_busy = 1; at_target = 0; step(1);
        expect_st("R2 transition blanks", 0, 0, 0, 0);
        slew_busy = 0; at_target = 1; step(1);
        ticks(WIN - 1);
        expect_st("R3 one tick short", 0, 0, 0, 0);
        ticks(1);
        expect_st("R3/R9 window done", 0, 0, 1, 1);

        // Restart inside the window
        slew_busy = 1; at_target = 0; step(1);
        expect_st("R2 new transition blanks", 0, 0, 0, 0);
        slew_busy = 0; at_target = 1; step(1);
        ticks(10);
        slew_busy = 1; at_target = 0; step(1);
        expect_st("R4 busy in window blanks", 0, 0, 0, 0);
        slew_busy = 0; at_target = 1; step(1);
        ticks(WIN - 1);
        expect_st("R4 full count restarted", 0, 0, 0, 0);
        ticks(1);
        expect_st("R4 restarted window done", 0, 0, 1, 1);

        // Deep-sleep entry
        sleep_req = 1; step(2);
        expect_st("R5 still run in sync delay", 0, 0, 1, 1);
        step(1);
        expect_st("R5 sleep mode blanked", 1, 0, 0, 0);
        slew_busy = 1; at_target = 0; step(1);
        slew_busy = 0; at_target = 1; step(1);
        ticks(WIN - 1);
        expect_st("R6 sleep one tick short", 1, 0, 0, 0);
        ticks(1);
        expect_st("R6 lower only", 1, 0, 1, 0);
        ticks(25);
        expect_st("R6 upper stays blanked", 1, 0, 1, 0);

        // Standard exit
        out_above = 0; sleep_req = 0; slew_busy = 1; at_target = 0;
        step(2);
        expect_st("R7 still sleep in sync delay", 1, 0, 0, 0);
        step(1);
        expect_st("R7 standard exit run blanked", 0, 0, 0, 0);
        slew_busy = 0; at_target = 1; step(1);
        ticks(WIN - 1);
        expect_st("R7 one tick short", 0, 0, 0, 0);
        ticks(1);
        expect_st("R7 both enabled", 0, 0, 1, 1);

        // Fast exit
        sleep_req = 1; step(3);
        expect_st("R5 second entry", 1, 0, 0, 0);
        out_above = 1; sleep_req = 0; step(3);
        expect_st("R8 fast exit held in skip", 1, 1, 0, 0);
        ticks(WIN + 5);
        expect_st("R8 still held while above", 1, 1, 0, 0);
        out_above = 0; step(1);
        expect_st("R8 phases back blanked", 0, 0, 0, 0);
        ticks(WIN - 1);
        expect_st("R8 one tick short", 0, 0, 0, 0);
        ticks(1);
        expect_st("R8/R9 both enabled", 0, 0, 1, 1);

        step(3);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule